// File: doc/BRIEF.md
# Floating-Point Status Accrual and Trap Unit

This block owns the floating-point status word and the exception-enable byte of the control word. Whenever the datapath retires a result, it reports the result's class, its sign and the exception bits the operation raised. The unit then rewrites the four condition-code flags and the per-operation exception byte.

A separate update strobe folds the current exception byte into a set of sticky accrued flags. The mapping is many-to-one. Underflow is recorded only when it comes with result inexactness. On the same strobe the unit compares the exception byte with the enable byte and, one cycle later, raises a trap request for one cycle.

Software can load either register through a write port and read both back at all times. A software write to the status word takes priority over a result update or a strobe in the same cycle.

Top module: `fpx_status_unit`

Status word layout (undefined bits always read 0):
- bits 27..24: condition codes N, Z, I, NaN.
- bits 15..8: exception byte. The bits, from 15 down to 8, are branch-unordered (0x80 in the byte), signaling NaN (0x40), operand error (0x20), overflow (0x10), underflow (0x08), divide-by-zero (0x04), inexact-2 (0x02) and inexact-1 (0x01).
- bits 7..3: accrued flags. From 7 down to 3 they are invalid-op, overflow, underflow, divide-by-zero and inexact.

Control word: bits 15..8 are the enable byte, with the same bit order as the exception byte. All other bits read 0.

Result class encoding on `res_class`: 0 number, 1 zero, 2 infinity, 3 quiet NaN, 4 signaling NaN.

## Requirements
- R1: After reset, `sr_q`, `cr_q` and `trap_req` are all zero.
- R2: A result update (`res_valid` with no status write) replaces the exception byte with `res_exc`. It clears all four condition codes and sets N (bit 27) equal to `res_sign`. It then sets Z (bit 26) for zero and I (bit 25) for infinity. A quiet NaN sets NaN (bit 24). A signaling NaN sets NaN and also the signaling-NaN exception bit (bit 14). A number sets no other code.
- R3: On a strobe, a set branch-unordered, signaling-NaN or operand-error bit sets accrued invalid-op (bit 7).
- R4: On a strobe, overflow sets accrued overflow (bit 6), and divide-by-zero sets accrued divide-by-zero (bit 4).
- R5: On a strobe, underflow sets accrued underflow (bit 5) only when inexact-2 is also set.
- R6: On a strobe, inexact-1, inexact-2 or overflow sets accrued inexact (bit 3).
- R7: Accrued flags are sticky. Result updates and strobes never clear them; only a status write does.
- R8: When an exception bit and its enable bit are both set at a strobe, `trap_req` is high for exactly the following cycle. Otherwise it stays low. The strobe uses the exception byte and enable byte held before that edge.
- R9: When a status write coincides with a result update or a strobe, the written value wins and no trap is requested.
- R10: Register writes load only the defined fields; all undefined bits of `sr_q` and `cr_q` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sr_en | input | 1 | Software write of the status word |
| wr_sr_data | input | 32 | Status write data |
| wr_cr_en | input | 1 | Software write of the control word |
| wr_cr_data | input | 32 | Control write data |
| res_valid | input | 1 | A result is retired this cycle |
| res_class | input | 3 | Result class |
| res_sign | input | 1 | Result sign |
| res_exc | input | 8 | Exception bits raised by the operation |
| upd_stb | input | 1 | Accrual and trap-check strobe |
| sr_q | output | 32 | Status word |
| cr_q | output | 32 | Control word |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The assertions assume that `res_class` carries only the five defined codes. They also assume that every input is driven to a known value in every cycle after reset, so that a one-hot check on the class codes and the sticky check are meaningful. The stimulus drives all inputs at the falling edge and returns them to idle between operations. It uses only legal class codes. It combines strobes with result updates and with status writes only in the patterns the priority rules define.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int SR_W    = 32;
  localparam int EXC_W   = 8;
  localparam int ACC_W   = 5;
  localparam int CC_W    = 4;
  localparam int CC_LSB  = 24;
  localparam int EXC_LSB = 8;
  localparam int ACC_LSB = 3;
  localparam int EN_LSB  = 8;

  // exception byte bit indices
  localparam int EX_BSUN  = 7;
  localparam int EX_SNAN  = 6;
  localparam int EX_OPERR = 5;
  localparam int EX_OVFL  = 4;
  localparam int EX_UNFL  = 3;
  localparam int EX_DZ    = 2;
  localparam int EX_INEX2 = 1;
  localparam int EX_INEX1 = 0;

  // accrued field bit indices
  localparam int AC_IOP  = 4;
  localparam int AC_OVFL = 3;
  localparam int AC_UNFL = 2;
  localparam int AC_DZ   = 1;
  localparam int AC_INEX = 0;

  // condition code bit indices
  localparam int CC_N   = 3;
  localparam int CC_Z   = 2;
  localparam int CC_I   = 1;
  localparam int CC_NAN = 0;

  typedef enum logic [2:0] {
    RC_NUM  = 3'd0,
    RC_ZERO = 3'd1,
    RC_INF  = 3'd2,
    RC_QNAN = 3'd3,
    RC_SNAN = 3'd4
  } res_class_e;

  function automatic logic [CC_W-1:0] cc_of(input logic [2:0] cls, input logic sign);
    logic [CC_W-1:0] c;
    c = '0;
    c[CC_N] = sign;
    case (cls)
      RC_ZERO: c[CC_Z]   = 1'b1;
      RC_INF:  c[CC_I]   = 1'b1;
      RC_QNAN: c[CC_NAN] = 1'b1;
      RC_SNAN: c[CC_NAN] = 1'b1;
      default: ;
    endcase
    return c;
  endfunction

  function automatic logic [ACC_W-1:0] accrue_of(input logic [EXC_W-1:0] e);
    logic [ACC_W-1:0] a;
    a[AC_IOP]  = e[EX_BSUN] | e[EX_SNAN] | e[EX_OPERR];
    a[AC_OVFL] = e[EX_OVFL];
    a[AC_UNFL] = e[EX_UNFL] & e[EX_INEX2];
    a[AC_DZ]   = e[EX_DZ];
    a[AC_INEX] = e[EX_INEX1] | e[EX_INEX2] | e[EX_OVFL];
    return a;
  endfunction
endpackage

// File: rtl/fpx_cc_gen.sv
module fpx_cc_gen
  import fpx_pkg::*;
(
  input  logic [2:0]       res_class,
  input  logic             res_sign,
  input  logic [EXC_W-1:0] res_exc,
  output logic [CC_W-1:0]  cc_next,
  output logic [EXC_W-1:0] exc_next
);
  logic snan_seen;

  always_comb begin
    snan_seen = (res_class == RC_SNAN);
    cc_next   = cc_of(res_class, res_sign);
    exc_next  = res_exc;
    exc_next[EX_SNAN] = res_exc[EX_SNAN] | snan_seen;
  end
endmodule

// File: rtl/fpx_accrue.sv
module fpx_accrue
  import fpx_pkg::*;
(
  input  logic [EXC_W-1:0] exc_cur,
  input  logic [EXC_W-1:0] en_cur,
  output logic [ACC_W-1:0] acc_set,
  output logic             trap_hit
);
  logic [EXC_W-1:0] armed;

  always_comb begin
    acc_set  = accrue_of(exc_cur);
    armed    = exc_cur & en_cur;
    trap_hit = |armed;
  end
endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_sr_en,
  input  logic [SR_W-1:0] wr_sr_data,
  input  logic            wr_cr_en,
  input  logic [SR_W-1:0] wr_cr_data,
  input  logic            res_valid,
  input  logic [2:0]      res_class,
  input  logic            res_sign,
  input  logic [7:0]      res_exc,
  input  logic            upd_stb,
  output logic [SR_W-1:0] sr_q,
  output logic [SR_W-1:0] cr_q,
  output logic            trap_req
);
  logic [CC_W-1:0]  cc_q;
  logic [EXC_W-1:0] exc_q;
  logic [ACC_W-1:0] acc_q;
  logic [EXC_W-1:0] en_q;
  logic             trap_q;

  logic [CC_W-1:0]  cc_next;
  logic [EXC_W-1:0] exc_next;
  logic [ACC_W-1:0] acc_set;
  logic             trap_hit;

  // named internal events
  logic res_take;
  logic upd_take;

  assign res_take = res_valid & ~wr_sr_en;
  assign upd_take = upd_stb & ~wr_sr_en;

  fpx_cc_gen u_cc (
    .res_class (res_class),
    .res_sign  (res_sign),
    .res_exc   (res_exc),
    .cc_next   (cc_next),
    .exc_next  (exc_next)
  );

  fpx_accrue u_acc (
    .exc_cur  (exc_q),
    .en_cur   (en_q),
    .acc_set  (acc_set),
    .trap_hit (trap_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q   <= '0;
      exc_q  <= '0;
      acc_q  <= '0;
      en_q   <= '0;
      trap_q <= 1'b0;
    end else begin
      if (wr_sr_en) begin
        cc_q  <= wr_sr_data[CC_LSB  +: CC_W];
        exc_q <= wr_sr_data[EXC_LSB +: EXC_W];
        acc_q <= wr_sr_data[ACC_LSB +: ACC_W];
      end else begin
        if (res_take) begin
          cc_q  <= cc_next;
          exc_q <= exc_next;
        end
        if (upd_take) acc_q <= acc_q | acc_set;
      end
      if (wr_cr_en) en_q <= wr_cr_data[EN_LSB +: EXC_W];
      trap_q <= upd_take & trap_hit;
    end
  end

  always_comb begin
    sr_q = '0;
    sr_q[CC_LSB  +: CC_W]  = cc_q;
    sr_q[EXC_LSB +: EXC_W] = exc_q;
    sr_q[ACC_LSB +: ACC_W] = acc_q;
    cr_q = '0;
    cr_q[EN_LSB +: EXC_W]  = en_q;
  end

  assign trap_req = trap_q;

  AST_TRAP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(upd_take)); // R8

  AST_ACCRUED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sr_en |=> ((acc_q & $past(acc_q)) == $past(acc_q))); // R7

  AST_UNFL_NEEDS_INEX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_q[AC_UNFL]) |-> ($past(wr_sr_en) || ($past(exc_q[EX_UNFL]) && $past(exc_q[EX_INEX2])))); // R5

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sr_en |=> (sr_q[EXC_LSB +: EXC_W] == $past(wr_sr_data[EXC_LSB +: EXC_W])) && !trap_req); // R9

  AST_CC_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    res_take |=> $onehot0(cc_q[CC_Z:CC_NAN])); // R2
endmodule

// File: tb/test_fpx_status_unit.sv
module test_fpx_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_sr_en = 1'b0;
  logic [31:0] wr_sr_data = '0;
  logic        wr_cr_en = 1'b0;
  logic [31:0] wr_cr_data = '0;
  logic        res_valid = 1'b0;
  logic [2:0]  res_class = '0;
  logic        res_sign = 1'b0;
  logic [7:0]  res_exc = '0;
  logic        upd_stb = 1'b0;
  logic [31:0] sr_q, cr_q;
  logic        trap_req;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] sr;
    logic [31:0] cr;
    logic        trap;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_sr = '0;
  logic [31:0] m_cr = '0;

  always #5 clk = ~clk;

  fpx_status_unit i_fpx_status_unit (
    .clk(clk), .rst_n(rst_n),
    .wr_sr_en(wr_sr_en), .wr_sr_data(wr_sr_data),
    .wr_cr_en(wr_cr_en), .wr_cr_data(wr_cr_data),
    .res_valid(res_valid), .res_class(res_class), .res_sign(res_sign),
    .res_exc(res_exc), .upd_stb(upd_stb),
    .sr_q(sr_q), .cr_q(cr_q), .trap_req(trap_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one operation per cycle, expected state pushed to the scoreboard
  task automatic step(input bit wsr, input logic [31:0] wsd,
                      input bit wcr, input logic [31:0] wcd,
                      input bit rv, input logic [2:0] rc, input bit rs,
                      input logic [7:0] rx, input bit us, input string tag);
    exp_t e;
    logic [7:0] ex;
    logic [4:0] ac;
    logic       tr;
    @(negedge clk);
    wr_sr_en = wsr; wr_sr_data = wsd; wr_cr_en = wcr; wr_cr_data = wcd;
    res_valid = rv; res_class = rc; res_sign = rs; res_exc = rx; upd_stb = us;
    ex = m_sr[15:8];
    tr = us && !wsr && ((m_sr[15:8] & m_cr[15:8]) != 8'h00);
    ac[4] = ex[7] || ex[6] || ex[5];
    ac[3] = ex[4];
    ac[2] = ex[3] && ex[1];
    ac[1] = ex[2];
    ac[0] = ex[1] || ex[0] || ex[4];
    if (wsr) m_sr = wsd & 32'h0F00_FFF8;
    else begin
      if (rv) begin
        m_sr[27] = rs;
        m_sr[26] = (rc == 3'd1);
        m_sr[25] = (rc == 3'd2);
        m_sr[24] = (rc == 3'd3) || (rc == 3'd4);
        m_sr[15:8] = rx | ((rc == 3'd4) ? 8'h40 : 8'h00);
      end
      if (us) m_sr[7:3] = m_sr[7:3] | ac;
    end
    if (wcr) m_cr = wcd & 32'h0000_FF00;
    e.sr = m_sr; e.cr = m_cr; e.trap = tr; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic result(input logic [2:0] rc, input bit rs, input logic [7:0] rx, input string tag);
    step(0, 0, 0, 0, 1, rc, rs, rx, 0, tag);
  endtask

  task automatic strobe(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic wsr(input logic [31:0] d, input string tag);
    step(1, d, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // monitor: compares outputs one time unit after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " sr"}, sr_q, e.sr);
        check({e.tag, " cr"}, cr_q, e.cr);
        check({e.tag, " trap"}, {31'b0, trap_req}, {31'b0, e.trap});
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 reset sr", sr_q, 32'h0);
    check("R1 reset cr", cr_q, 32'h0);
    check("R1 reset trap", {31'b0, trap_req}, 32'h0);

    // R2 condition codes per class
    result(3'd4, 1, 8'h00, "R2 snan neg");
    result(3'd3, 0, 8'h20, "R2 qnan");
    result(3'd1, 1, 8'h00, "R2 zero neg");
    result(3'd2, 0, 8'h02, "R2 inf");
    result(3'd0, 1, 8'h00, "R2 num neg");
    result(3'd0, 0, 8'h00, "R2 num pos");

    // R3 invalid-op sources
    wsr(32'h0, "R7 clear");
    result(3'd0, 0, 8'h80, "R3 bsun");
    strobe("R3 bsun acc");
    wsr(32'h0, "R7 clear");
    result(3'd3, 0, 8'h20, "R3 operr");
    strobe("R3 operr acc");
    wsr(32'h0, "R7 clear");
    result(3'd4, 0, 8'h00, "R3 snan");
    strobe("R3 snan acc");

    // R4 overflow and divide-by-zero (overflow also gives inexact, R6)
    wsr(32'h0, "R7 clear");
    result(3'd2, 0, 8'h10, "R4 ovfl");
    strobe("R4 R6 ovfl acc");
    wsr(32'h0, "R7 clear");
    result(3'd2, 1, 8'h04, "R4 dz");
    strobe("R4 dz acc");

    // R5 underflow gating
    wsr(32'h0, "R7 clear");
    result(3'd1, 0, 8'h08, "R5 unfl alone");
    strobe("R5 unfl alone no acc");
    result(3'd1, 0, 8'h09, "R5 unfl inex1");
    strobe("R5 unfl inex1 no unfl acc");
    result(3'd1, 0, 8'h0A, "R5 unfl inex2");
    strobe("R5 unfl inex2 acc");

    // R6 inexact sources
    wsr(32'h0, "R7 clear");
    result(3'd0, 0, 8'h01, "R6 inex1");
    strobe("R6 inex1 acc");
    wsr(32'h0, "R7 clear");
    result(3'd0, 0, 8'h02, "R6 inex2");
    strobe("R6 inex2 acc");

    // R7 sticky across clean results and strobes
    result(3'd0, 0, 8'h00, "R7 clean result");
    strobe("R7 clean strobe keeps acc");
    idle("R7 idle");
    wsr(32'h0000_00F8, "R7 write all acc");
    result(3'd1, 0, 8'h00, "R7 result keeps acc");
    wsr(32'h0, "R7 write clears acc");

    // R8 trap
    step(0, 0, 1, 32'h0000_1000, 0, 0, 0, 0, 0, "R10 cr ovfl en");
    result(3'd2, 0, 8'h10, "R8 ovfl exc");
    strobe("R8 trap pulse");
    idle("R8 trap drops");
    strobe("R8 second strobe");
    idle("R8 drops again");
    result(3'd0, 0, 8'h04, "R8 dz not enabled");
    strobe("R8 no trap");
    idle("R8 idle");
    step(0, 0, 1, 32'h0000_0400, 0, 0, 0, 0, 1, "R8 strobe uses old enable");
    strobe("R8 new enable traps");
    idle("R8 idle2");

    // R9 write priority
    step(1, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 1, "R9 write with strobe");
    result(3'd2, 1, 8'h10, "R9 setup");
    step(1, 32'h0400_2000, 0, 0, 1, 3'd1, 0, 8'h08, 1, "R9 write with result and strobe");
    idle("R9 idle");

    // R10 undefined bits masked
    wsr(32'hFFFF_FFFF, "R10 sr all ones");
    step(0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R10 cr all ones");
    wsr(32'h0, "R10 clear");
    step(0, 0, 1, 32'h0, 0, 0, 0, 0, 0, "R10 cr clear");
    idle("flush");
    idle("flush");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule